// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a processor-side register port and a configuration access port. It holds two registers: a configuration address register and a configuration data window. When software writes the address register, the block checks the two lowest bits of the value. A value with both bits clear is a type 0 address that selects its target device with a one-hot field. The block scans that field, recovers a device number, and stores the address in the standard enabled configuration format for bus 0. Any other value is a type 1 address and is stored exactly as written.

An access to the data window does not complete locally. It is forwarded to the configuration port together with the stored, translated address. The processor side waits until the configuration port accepts the access.

Both sides use a valid/ready handshake. The processor side sees `req_ready` low for as long as a forwarded access is outstanding. A master must hold its request, unchanged, until it sees `req_valid` and `req_ready` high on the same edge. The configuration side raises `cfg_valid` and holds it, with every field stable, until `cfg_ready` is seen high. Each accepted request produces exactly one one-cycle `rsp_valid` pulse. There is no way to stall the response.

Top module: `cfg_addr_xlate`

## Requirements
- R1: After reset the stored address is 0, `req_ready` is 1, and `cfg_valid` and `rsp_valid` are 0.
- R2: An address-register write whose merged value has bits 1:0 equal to 00 is translated. Any other merged value is stored unmodified.
- R3: For a type 0 value, bits 11 to 23 are scanned upward. The lowest set bit at position p gives device number p-10, so bit 11 gives device 1 and bit 23 gives device 13. Higher set bits and bits 30:24 are ignored.
- R4: A type 0 value with none of bits 23:11 set gives device number 0.
- R5: A translated address has bit 31 set, bits 30:16 zero, the device number in bits 15:11, and bits 10:0 copied from the written value.
- R6: An address-register read returns the stored (translated) value on `rsp_rdata`, with `rsp_valid` high in the cycle after the request is accepted. An address-register write also responds in that cycle, with `rsp_rdata` equal to 0.
- R7: In an address-register write, byte lane b (bits 8b+7:8b) takes write data only where `req_be[b]` is 1. The other lanes keep the stored value. Translation is applied to the merged word.
- R8: A data-register access accepted on one edge raises `cfg_valid` on the next cycle. In that cycle `cfg_addr` equals the stored address, and `cfg_write`, `cfg_wdata` and `cfg_be` are copied from the request. All of these stay stable until `cfg_ready` is seen.
- R9: While a forwarded access is outstanding, `req_ready` is 0. In the cycle after the configuration handshake, `rsp_valid` is 1 and `rsp_rdata` carries `cfg_rdata` for a read, or 0 for a write.
- R10: Address-register accesses never raise `cfg_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Request accepted; low while a forwarded access waits |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data_sel | input | 1 | 0 = address register, 1 = data window |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for the write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Response data |
| cfg_valid | output | 1 | Configuration access request |
| cfg_ready | input | 1 | Configuration port accepts the access |
| cfg_write | output | 1 | Configuration access direction |
| cfg_addr | output | 32 | Stored translated address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_be | output | 4 | Configuration byte enables |
| cfg_rdata | input | 32 | Read data, valid while `cfg_ready` is high |

## Verification
The hardest case to reach is a partial-byte write that changes the address type. Because the stored value is merged with the new lanes before it is classified, a type 1 value can turn into type 0 when only its low byte is rewritten. The stimulus first stores a type 1 word, then writes only lane 0 with a value whose low bits are clear. The expected device number comes from the select bits kept in the lanes that were not written. Back-pressure is covered by holding `cfg_ready` low for several cycles and checking that every configuration-side field stays stable and `req_ready` stays low throughout.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int SEL_LO = 11;
  localparam int SEL_HI = 23;
  localparam int DEV_W  = 5;
  localparam int PAD_W  = DATA_W - 1 - DEV_W - SEL_LO;

  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    logic             write;
    word_t            wdata;
    logic [BE_W-1:0]  be;
  } cfg_op_t;
endpackage

// File: rtl/cfgx_dev_scan.sv
module cfgx_dev_scan #(
  parameter int LO    = 11,
  parameter int HI    = 23,
  parameter int DEV_W = 5
) (
  input  logic [HI:LO]      sel,
  output logic [DEV_W-1:0]  dev
);
  // lowest set bit wins: iterate downward so the last hit is the lowest
  always_comb begin
    dev = '0;
    for (int i = HI; i >= LO; i--) begin
      if (sel[i]) dev = DEV_W'(i - LO + 1);
    end
  end
endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
  import cfgx_pkg::*;
(
  input  word_t raw,
  output word_t xlated
);
  logic [DEV_W-1:0] dev;
  logic             is_type0;

  cfgx_dev_scan #(.LO(SEL_LO), .HI(SEL_HI), .DEV_W(DEV_W)) u_scan (
    .sel (raw[SEL_HI:SEL_LO]),
    .dev (dev)
  );

  assign is_type0 = (raw[1:0] == 2'b00);
  assign xlated   = is_type0 ? {1'b1, {PAD_W{1'b0}}, dev, raw[SEL_LO-1:0]} : raw;
endmodule

// File: rtl/cfgx_addr_reg.sv
module cfgx_addr_reg
  import cfgx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  word_t           wdata,
  input  logic [BE_W-1:0] be,
  output word_t           q
);
  word_t merged;
  word_t xlated;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign merged[8*b +: 8] = be[b] ? wdata[8*b +: 8] : q[8*b +: 8];
  end

  cfgx_xlate u_xlate (
    .raw    (merged),
    .xlated (xlated)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= xlated;
  end
endmodule

// File: rtl/cfgx_fwd.sv
module cfgx_fwd
  import cfgx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  cfg_op_t         op,
  input  logic            cfg_ready,
  input  word_t           cfg_rdata,
  output logic            busy,
  output logic            cfg_write,
  output word_t           cfg_wdata,
  output logic [BE_W-1:0] cfg_be,
  output logic            done,
  output word_t           done_rdata
);
  cfg_op_t op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      op_q <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      op_q <= op;
    end else if (busy && cfg_ready) begin
      busy <= 1'b0;
    end
  end

  assign cfg_write  = op_q.write;
  assign cfg_wdata  = op_q.wdata;
  assign cfg_be     = op_q.be;
  assign done       = busy && cfg_ready;
  assign done_rdata = op_q.write ? '0 : cfg_rdata;
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cfgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_data_sel,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic              cfg_write,
  output logic [DATA_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_wdata,
  output logic [BE_W-1:0]   cfg_be,
  input  logic [DATA_W-1:0] cfg_rdata
);
  logic    accept, addr_wr, addr_rd, data_go;
  logic    busy, fwd_done;
  word_t   addr_q, fwd_rdata;
  cfg_op_t op;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign addr_wr   = accept && !req_data_sel &&  req_write;
  assign addr_rd   = accept && !req_data_sel && !req_write;
  assign data_go   = accept &&  req_data_sel;
  assign op        = '{write: req_write, wdata: req_wdata, be: req_be};

  cfgx_addr_reg u_areg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (addr_wr),
    .wdata (req_wdata),
    .be    (req_be),
    .q     (addr_q)
  );

  cfgx_fwd u_fwd (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (data_go),
    .op         (op),
    .cfg_ready  (cfg_ready),
    .cfg_rdata  (cfg_rdata),
    .busy       (busy),
    .cfg_write  (cfg_write),
    .cfg_wdata  (cfg_wdata),
    .cfg_be     (cfg_be),
    .done       (fwd_done),
    .done_rdata (fwd_rdata)
  );

  assign cfg_valid = busy;
  assign cfg_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= addr_wr || addr_rd || fwd_done;
      if (addr_rd)       rsp_rdata <= addr_q;
      else if (addr_wr)  rsp_rdata <= '0;
      else if (fwd_done) rsp_rdata <= fwd_rdata;
    end
  end
endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_data_sel,
  input logic        rsp_valid,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic        cfg_write,
  input logic [31:0] cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic [3:0]  cfg_be
);
  a_r8_launch: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_data_sel |=> cfg_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_wdata)
                                && $stable(cfg_write) && $stable(cfg_be));

  a_r9_wait: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> !req_ready);

  a_r9_rsp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready |=> rsp_valid && !cfg_valid);

  a_r10_addr_local: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_data_sel |=> !cfg_valid && rsp_valid);

  a_r5_format: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && (cfg_addr[1:0] == 2'b00) |-> cfg_addr[31] && (cfg_addr[30:16] == 15'd0));
endmodule

bind cfg_addr_xlate cfgx_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_data_sel (req_data_sel),
  .rsp_valid    (rsp_valid),
  .cfg_valid    (cfg_valid),
  .cfg_ready    (cfg_ready),
  .cfg_write    (cfg_write),
  .cfg_addr     (cfg_addr),
  .cfg_wdata    (cfg_wdata),
  .cfg_be       (cfg_be)
);

// File: tb/tb_cfg_addr_xlate.sv
`timescale 1ns/1ps
module tb_cfg_addr_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_data_sel = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, rsp_valid, cfg_valid, cfg_write;
  logic [31:0] rsp_rdata, cfg_addr, cfg_wdata;
  logic [3:0]  cfg_be;
  logic        cfg_ready = 1'b0;
  logic [31:0] cfg_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cfg_addr_xlate dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_data_sel(req_data_sel), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_write(cfg_write),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata)
  );

  // {written value, expected stored value}
  localparam logic [63:0] VEC [0:8] = '{
    {32'h0000_0800, 32'h8000_0800},  // R3 bit 11 -> device 1
    {32'h0080_0004, 32'h8000_6804},  // R3 bit 23 -> device 13
    {32'h0000_3010, 32'h8000_1010},  // R3 lowest of 12,13 wins
    {32'h1234_0000, 32'h8000_4000},  // R3 bit 18 -> device 8, upper dropped
    {32'h0000_07FC, 32'h8000_07FC},  // R4 no select bit
    {32'h8001_0A01, 32'h8001_0A01},  // R2 type 1 pass-through
    {32'hFFFF_FFFE, 32'hFFFF_FFFE},  // R2 bits 1:0 = 10 pass-through
    {32'h0000_0000, 32'h8000_0000},  // R4 all clear
    {32'hFF80_0000, 32'h8000_6800}   // R5 bits 30:16 cleared
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic reg_acc(input logic wr, input logic [31:0] wd, input logic [3:0] be,
                         output logic [31:0] rd, output logic rv, output logic cv);
    @(negedge clk);
    req_valid = 1'b1; req_data_sel = 1'b0; req_write = wr; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; rv = rsp_valid; cv = cfg_valid;
  endtask

  task automatic data_acc(input logic wr, input logic [31:0] wd, input logic [3:0] be,
                          input int wait_n, input logic [31:0] rd_in, input logic [31:0] exp_addr);
    @(negedge clk);
    req_valid = 1'b1; req_data_sel = 1'b1; req_write = wr; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 cfg_valid raised", {31'd0, cfg_valid}, 32'd1);
    chk("R8 cfg_addr", cfg_addr, exp_addr);
    chk("R8 cfg_write", {31'd0, cfg_write}, {31'd0, wr});
    chk("R8 cfg_be", {28'd0, cfg_be}, {28'd0, be});
    if (wr) chk("R8 cfg_wdata", cfg_wdata, wd);
    chk("R9 req_ready low while pending", {31'd0, req_ready}, 32'd0);
    for (int k = 0; k < wait_n; k++) begin
      @(negedge clk);
      chk("R8 held cfg_valid", {31'd0, cfg_valid}, 32'd1);
      chk("R8 held cfg_addr", cfg_addr, exp_addr);
      chk("R9 held req_ready", {31'd0, req_ready}, 32'd0);
      chk("R6 no early rsp", {31'd0, rsp_valid}, 32'd0);
    end
    cfg_ready = 1'b1; cfg_rdata = rd_in;
    @(negedge clk);
    cfg_ready = 1'b0; cfg_rdata = 32'hAAAA_5555;
    chk("R9 rsp_valid after ack", {31'd0, rsp_valid}, 32'd1);
    chk("R9 rsp_rdata", rsp_rdata, wr ? 32'd0 : rd_in);
    chk("R9 cfg_valid dropped", {31'd0, cfg_valid}, 32'd0);
    chk("R9 req_ready restored", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic rv, cv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 cfg_valid", {31'd0, cfg_valid}, 32'd0);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    reg_acc(1'b0, 32'h0, 4'h0, rd, rv, cv);
    chk("R1 stored address", rd, 32'd0);
    chk("R6 read rsp_valid", {31'd0, rv}, 32'd1);

    // vector table: write then read back
    for (int i = 0; i < 9; i++) begin
      reg_acc(1'b1, VEC[i][63:32], 4'hF, rd, rv, cv);
      chk("R6 write rsp", {31'd0, rv}, 32'd1);
      chk("R6 write rdata zero", rd, 32'd0);
      chk("R10 no cfg on write", {31'd0, cv}, 32'd0);
      reg_acc(1'b0, 32'h0, 4'h0, rd, rv, cv);
      chk("R2 R3 R4 R5 readback", rd, VEC[i][31:0]);
      chk("R10 no cfg on read", {31'd0, cv}, 32'd0);
    end

    // R7 partial write turns a type 1 value into type 0
    reg_acc(1'b1, 32'h1122_3303, 4'hF, rd, rv, cv);
    reg_acc(1'b0, 32'h0, 4'h0, rd, rv, cv);
    chk("R2 type1 stored", rd, 32'h1122_3303);
    reg_acc(1'b1, 32'hAAAA_AA00, 4'b0001, rd, rv, cv);
    reg_acc(1'b0, 32'h0, 4'h0, rd, rv, cv);
    chk("R7 merged then translated", rd, 32'h8000_1300);
    // R7 masked upper lanes leave the value as is
    reg_acc(1'b1, 32'h0000_0000, 4'b0000, rd, rv, cv);
    reg_acc(1'b0, 32'h0, 4'h0, rd, rv, cv);
    chk("R7 no lanes enabled", rd, 32'h8000_1300);

    // R8 R9 forwarded write with back-pressure, then reads
    data_acc(1'b1, 32'hDEAD_BEEF, 4'hF, 3, 32'h0, 32'h8000_1300);
    data_acc(1'b0, 32'h0, 4'b0011, 0, 32'h0BAD_F00D, 32'h8000_1300);
    reg_acc(1'b1, 32'h8000_0101, 4'hF, rd, rv, cv);
    data_acc(1'b0, 32'h0, 4'hF, 5, 32'h1357_9BDF, 32'h8000_0101);
    data_acc(1'b1, 32'h0102_0304, 4'b1010, 1, 32'h0, 32'h8000_0101);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule